// File: doc/BRIEF.md
# Glitch-Free Failover Clock Selector

This block picks one of two unrelated clocks and passes it to a single clock output. A change of the select line never produces a runt pulse or a short cycle. The gate of the departing clock is shut at that clock's own falling edge. The gate of the arriving clock opens only after the closure has been seen in the arriving clock's domain. If the departing clock has died, the arriving side waits a fixed number of its own edges and then forces the dead gate shut, so the handover still completes.

Each source has a valid flag that stands in for an amplitude detector. When the flag of the selected source drops, the output freezes at the level it had and stops toggling. A later switchover then behaves like the stuck-high or stuck-low case, depending on that frozen level. A raw mode turns the block into a plain combinational two-way mux. An active-low power-on reset puts both domains into a known closed state, with the output low.

Top module: `clk_failover_mux`

## Requirements
- R1: While `pwr_rst_n` is low and `raw_mode` is low, `clk_o` is held at 0.
- R2: With `raw_mode` low, `sel` = 0 selects `clk0` and `sel` = 1 selects `clk1`. Within 40 cycles of the arriving clock after `sel` settles, `clk_o` equals the selected clock.
- R3: A handover between two running clocks (period ratio at most 1.5:1) works the same in both directions. No high or low phase of `clk_o` is shorter than the shorter of the two source half-periods.
- R4: When the valid flag (`src0_ok` or `src1_ok`, active high) of the selected source goes low, `clk_o` keeps the level it had at that moment and does not toggle until the flag returns.
- R5: If the departing source is stuck high, `clk_o` stays high for a bounded number of arriving-clock edges, then goes low, then follows the arriving clock. Each phase of the stretched cycle lasts at least half the arriving clock's period.
- R6: If the departing source is stuck low, `clk_o` stays low for a bounded number of arriving-clock edges and then follows the arriving clock.
- R7: With `raw_mode` high, `clk_o` equals `sel ? clk1 : clk0` with no clocked delay.
- R8: The two source gates are never open at the same time.
- R9: If no closure is seen within `TMO_EDGES` arriving-clock edges, the arriving side forces the departing gate shut, and that gate stays shut while the force is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Source clock 0 |
| clk1 | input | 1 | Source clock 1 |
| sel | input | 1 | Source choice: 0 picks clk0, 1 picks clk1 |
| src0_ok | input | 1 | Source 0 valid flag, active high |
| src1_ok | input | 1 | Source 1 valid flag, active high |
| raw_mode | input | 1 | High: plain combinational mux, no runt protection |
| pwr_rst_n | input | 1 | Active-low power-on reset |
| clk_o | output | 1 | Selected clock |

## Verification
The bench covers four hazards:
- A handover between two live clocks. A design that opens the new gate too early shows a phase shorter than either half-period.
- A frozen-high source. A design without the forced closure keeps `clk_o` stuck high forever; one that opens the new gate right after forcing produces a short low phase.
- A source stopped low. A design that waits for an acknowledge from the dead side never moves to the new clock.
- A valid flag dropping in each output state, plus raw mode. A missing freeze shows the source still toggling; a clocked raw path shows a lag after `sel` changes.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int unsigned NUM_SRC = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  function automatic int unsigned peer_of(input int unsigned idx);
    return (idx == 0) ? 1 : 0;
  endfunction
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= {STAGES{RST_VAL}};
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfm_hold.sv
module cfm_hold (
  input  logic clk_in,
  input  logic ok,
  output logic clk_eff
);
  logic held;

  // transparent while the source is healthy, keeps the last level otherwise
  always_latch begin
    if (ok) held <= clk_in;
  end

  assign clk_eff = ok ? clk_in : held;
endmodule

// File: rtl/cfm_lane.sv
module cfm_lane #(
  parameter int unsigned IDX         = 0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMO_EDGES   = 16
) (
  input  logic src_clk,
  input  logic pwr_rst_n,
  input  logic sel,
  input  logic peer_en,
  input  logic peer_kill,
  output logic gate_en,
  output logic kill_q
);
  localparam int unsigned CW      = $clog2(TMO_EDGES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(TMO_EDGES);
  localparam logic        IDX_BIT = (IDX != 0);

  logic          lane_rst;
  logic          want;
  logic          peer_off;
  logic          clr_ctl;
  logic          timed_out;
  logic [CW-1:0] wait_cnt;

  // a forced closure from the peer also wipes this lane's request state
  assign clr_ctl = peer_kill | ~pwr_rst_n;

  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst (
    .clk (src_clk),
    .arst(~pwr_rst_n),
    .d   (1'b0),
    .q   (lane_rst)
  );

  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_want (
    .clk (src_clk),
    .arst(clr_ctl),
    .d   (sel == IDX_BIT),
    .q   (want)
  );

  cfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack (
    .clk (src_clk),
    .arst(~pwr_rst_n),
    .d   (~peer_en),
    .q   (peer_off)
  );

  // counts own edges spent waiting for the peer to report its gate closed
  always_ff @(posedge src_clk) begin
    if (lane_rst || !want || gate_en || peer_off) wait_cnt <= '0;
    else if (wait_cnt != CNT_MAX)                 wait_cnt <= wait_cnt + 1'b1;
  end

  assign timed_out = (wait_cnt == CNT_MAX);

  // force line: raised after the timeout, dropped once this gate is open
  always_ff @(negedge src_clk or posedge clr_ctl) begin
    if (clr_ctl) kill_q <= 1'b0;
    else         kill_q <= !lane_rst && want && !gate_en && (kill_q || timed_out);
  end

  // gate changes only while this source is low
  always_ff @(negedge src_clk or posedge clr_ctl) begin
    if (clr_ctl) gate_en <= 1'b0;
    else         gate_en <= !lane_rst && want && (gate_en || peer_off || kill_q);
  end
endmodule

// File: rtl/clk_failover_mux.sv
module clk_failover_mux
  import cfm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMO_EDGES   = 16
) (
  input  logic clk0,
  input  logic clk1,
  input  logic sel,
  input  logic src0_ok,
  input  logic src1_ok,
  input  logic raw_mode,
  input  logic pwr_rst_n,
  output logic clk_o
);
  src_vec_t raw_clk;
  src_vec_t ok_vec;
  src_vec_t src_clk;
  src_vec_t gate_en;
  src_vec_t kill;

  assign raw_clk = {clk1, clk0};
  assign ok_vec  = {src1_ok, src0_ok};

  generate
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_lane
      localparam int unsigned PEER = peer_of(gi);

      cfm_hold u_hold (
        .clk_in (raw_clk[gi]),
        .ok     (ok_vec[gi]),
        .clk_eff(src_clk[gi])
      );

      cfm_lane #(
        .IDX        (gi),
        .SYNC_STAGES(SYNC_STAGES),
        .TMO_EDGES  (TMO_EDGES)
      ) u_lane (
        .src_clk  (src_clk[gi]),
        .pwr_rst_n(pwr_rst_n),
        .sel      (sel),
        .peer_en  (gate_en[PEER]),
        .peer_kill(kill[PEER]),
        .gate_en  (gate_en[gi]),
        .kill_q   (kill[gi])
      );
    end
  endgenerate

  always_comb begin
    if (raw_mode) clk_o = sel ? clk1 : clk0;
    else          clk_o = |(src_clk & gate_en);
  end
endmodule

// File: rtl/cfm_chk.sv
module cfm_chk (
  input logic       pwr_rst_n,
  input logic       clk0,
  input logic       clk1,
  input logic [1:0] gate_en,
  input logic [1:0] kill
);
  always_comb begin
    if (pwr_rst_n) begin
      // R8
      gates_excl_chk: assert (!(gate_en[0] && gate_en[1]))
        else $error("both source gates open");
    end
  end

  // R9
  kill1_shut_chk: assert property (@(posedge clk1) disable iff (!pwr_rst_n)
    kill[1] |-> !gate_en[0]);

  // R9
  kill0_shut_chk: assert property (@(posedge clk0) disable iff (!pwr_rst_n)
    kill[0] |-> !gate_en[1]);

  // R3
  open1_order_chk: assert property (@(posedge clk1) disable iff (!pwr_rst_n)
    $rose(gate_en[1]) |-> !gate_en[0]);

  // R3
  open0_order_chk: assert property (@(posedge clk0) disable iff (!pwr_rst_n)
    $rose(gate_en[0]) |-> !gate_en[1]);
endmodule

bind clk_failover_mux cfm_chk u_chk (
  .pwr_rst_n(pwr_rst_n),
  .clk0     (clk0),
  .clk1     (clk1),
  .gate_en  (gate_en),
  .kill     (kill)
);

// File: tb/sim_clk_failover_mux.sv
`timescale 1ns/100ps
module sim_clk_failover_mux;
  logic clk0 = 1'b0, clk1 = 1'b0;
  logic run0 = 1'b1, run1 = 1'b1;
  logic sel = 1'b0, src0_ok = 1'b1, src1_ok = 1'b1, raw_mode = 1'b0, pwr_rst_n = 1'b0;
  logic clk_o;

  // kinds: 0 follow clk0, 1 follow clk1, 2 steady low, 3 steady high
  typedef struct { int kind; string tag; } item_t;
  item_t q[$];
  bit    busy = 1'b0;
  int    n_chk = 0, n_bad = 0;

  real   last_t = -1000.0;
  real   win_min = 1.0e9;
  bit    win_on = 1'b0;
  bit    glitch_on = 1'b1;
  int    glitch_cnt = 0;

  clk_failover_mux u0 (
    .clk0(clk0), .clk1(clk1), .sel(sel), .src0_ok(src0_ok), .src1_ok(src1_ok),
    .raw_mode(raw_mode), .pwr_rst_n(pwr_rst_n), .clk_o(clk_o)
  );

  // 125 MHz primary source, 100 MHz secondary
  initial forever begin #4; if (run0) clk0 = ~clk0; end
  initial forever begin #5; if (run1) clk1 = ~clk1; end

  // phase-width monitor: 4 ns is the shorter source half-period
  always @(clk_o) begin
    real w;
    w = $realtime - last_t;
    if (glitch_on && w < 3.99) glitch_cnt++;
    if (win_on && w < win_min) win_min = w;
    last_t = $realtime;
  end

  // scoreboard monitor: pops an expected item and compares 40 samples
  initial forever begin
    item_t it;
    logic  e, a0, e0;
    int    mism;
    wait (q.size() > 0);
    it = q.pop_front();
    busy = 1'b1;
    mism = 0; a0 = 1'b0; e0 = 1'b0;
    #0.5;
    for (int k = 0; k < 40; k++) begin
      case (it.kind)
        0:       e = clk0;
        1:       e = clk1;
        2:       e = 1'b0;
        default: e = 1'b1;
      endcase
      if (clk_o !== e) begin
        if (mism == 0) begin a0 = clk_o; e0 = e; end
        mism++;
      end
      #1;
    end
    #0.5;
    n_chk++;
    if (mism != 0) begin
      n_bad++;
      $display("FAIL %s: out=%b expected %b (%0d of 40 samples differ)", it.tag, a0, e0, mism);
    end
    busy = 1'b0;
  end

  task automatic expect_win(input int kind, input string tag);
    item_t it;
    it.kind = kind;
    it.tag  = tag;
    q.push_back(it);
    #1;
    wait (!busy && q.size() == 0);
  endtask

  task automatic check_real(input bit ok, input string tag, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0.2f expected %0.2f", tag, act, exp);
    end
  endtask

  task automatic run_all();
    #50;
    expect_win(2, "R1 output low in reset");
    pwr_rst_n = 1'b1;
    #300;
    expect_win(0, "R2 sel=0 follows clk0");
    sel = 1'b1;
    #300;
    expect_win(1, "R3 R2 handover 0 to 1");
    sel = 1'b0;
    #300;
    expect_win(0, "R3 R2 handover 1 to 0");

    // freeze source 0 while high, then hand over to clk1
    @(posedge clk0); #1; src0_ok = 1'b0;
    #100;
    expect_win(3, "R4 frozen high level held");
    win_min = 1.0e9; win_on = 1'b1;
    sel = 1'b1;
    #60;
    expect_win(3, "R5 stays high after select change");
    #300;
    win_on = 1'b0;
    check_real(win_min >= 4.99, "R5 stretched phase width", win_min, 5.0);
    expect_win(1, "R5 R9 follows clk1 after stuck-high source");
    @(posedge clk0); #1; src0_ok = 1'b1;
    #100;

    // stop clk1 low, hand over to clk0
    @(negedge clk1); #1; run1 = 1'b0;
    #100;
    sel = 1'b0;
    #60;
    expect_win(2, "R6 stays low after select change");
    #300;
    expect_win(0, "R6 R9 follows clk0 after stuck-low source");
    run1 = 1'b1;
    #100;
    sel = 1'b1;
    #400;
    expect_win(1, "R3 R2 handover after revival");

    // freeze source 1 while low
    @(negedge clk1); #1; src1_ok = 1'b0;
    #60;
    expect_win(2, "R4 frozen low level held");
    @(negedge clk1); #1; src1_ok = 1'b1;
    #100;

    // raw mode
    glitch_on = 1'b0;
    raw_mode = 1'b1;
    #20;
    sel = 1'b0;
    expect_win(0, "R7 raw mode picks clk0 at once");
    #300;
    sel = 1'b1;
    expect_win(1, "R7 raw mode picks clk1 at once");
    #300;
    raw_mode = 1'b0;
    #50;
    last_t = -1000.0;
    glitch_on = 1'b1;
    #100;
    expect_win(1, "R2 gated path after raw mode");

    check_real(glitch_cnt == 0, "R3 R8 no runt phase on output", real'(glitch_cnt), 0.0);
  endtask

  initial begin
    fork
      run_all();
      begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule